// File: doc/BRIEF.md
# I2S Slave Audio Serial Port

This block moves stereo samples between the system clock domain and an audio codec that owns all serial timing. The codec supplies the bit clock and two frame clocks, one for the record direction and one for the playback direction, and this block follows them. On the record side, the serial data line is turned into a left and right sample pair. On the playback side, a left and right pair is taken from the system side and shifted out on the playback data line.

The serial word length can be 16, 20, 24 or 32 bits. Inside the chip every sample is a 24-bit signed two's complement value. Received words are left-aligned into 24 bits. Outgoing 24-bit values are cut down or zero-extended at the low end to fit the serial word length. The three codec clocks are brought into the system clock domain through two-flop synchronisers, and all framing is derived from the edges found there. The system clock therefore has to run several times faster than the bit clock.

Top module: `i2s_slave_port`

## Requirements
- R1: Record data is sampled on bit clock rising edges, most significant bit first. A word's MSB arrives in the bit period after the record frame clock changes level. Frame clock low selects the left channel and high selects the right channel.
- R2: Word length code `wlen` selects the serial length: 0 is 16 bits, 1 is 20 bits, 2 is 24 bits and 3 is 32 bits. A received 16- or 20-bit word goes to the upper bits of the 24-bit sample, with zeros below it. A 24-bit word is passed unchanged. A 32-bit word keeps its upper 24 bits.
- R3: Record bits that arrive after the last bit of a word, in the same channel slot, do not change the captured sample.
- R4: `rx_valid` is a one-cycle pulse, given exactly once for each left word followed by a right word. In that cycle `rx_left` and `rx_right` carry the pair, and they hold it until the next pulse.
- R5: `dacdat` changes only after a bit clock falling edge. Each playback word is sent MSB first, starting in the bit period after the playback frame clock changes level. The word is the top n bits of the 24-bit sample followed by zeros: for 16 and 20 bits the low sample bits are dropped, and for 32 bits eight zeros are appended.
- R6: `dacdat` is low in every bit period of a slot that carries no word bit.
- R7: `tx_req` pulses for one cycle after each falling edge of the playback frame clock. The `tx_left` and `tx_right` values present in the cycle before the pulse are the pair sent in the frame that begins there.
- R8: The word length is taken at the start of each word. A 32-bit word fills a 32-bit slot exactly, and its LSB falls in the first bit period of the following slot.
- R9: While reset is held and on the first cycle after it is released, `rx_valid`, `tx_req`, `dacdat`, `rx_left` and `rx_right` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Serial bit clock from the codec |
| adclrck | input | 1 | Record frame clock (low = left) |
| adcdat | input | 1 | Record serial data |
| daclrck | input | 1 | Playback frame clock (low = left) |
| dacdat | output | 1 | Playback serial data |
| wlen | input | 2 | Word length code (0:16, 1:20, 2:24, 3:32) |
| rx_left | output | 24 | Last received left sample |
| rx_right | output | 24 | Last received right sample |
| rx_valid | output | 1 | One-cycle strobe for a new received pair |
| tx_left | input | 24 | Left sample to play |
| tx_right | input | 24 | Right sample to play |
| tx_req | output | 1 | One-cycle strobe: pair taken, present the next |

## Verification
A bit counter or word length register that has gone wrong shows up within one channel slot. It appears as a received sample with its bits moved sideways, or as a playback word whose final captured bits are wrong. An error in the frame clock history, meaning the channel or start tracking, shows at the first word boundary after it. It appears as swapped channels, a missing or extra `rx_valid`, or a `tx_req` in the wrong half of the frame. The sweep covers all four lengths with both a full 32-bit slot and padded slots, so an off-by-one at the word edges changes a compared value in the same frame.

// File: rtl/i2s_port_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the I2S slave port: word length codes and their
// bit counts. Assumes the serial word never exceeds 32 bits.
package i2s_port_pkg;

    typedef enum logic [1:0] {
        WL_16 = 2'd0,
        WL_20 = 2'd1,
        WL_24 = 2'd2,
        WL_32 = 2'd3
    } wlen_e;

    // Number of serial bits carried by a word for a given length code.
    function automatic logic [5:0] wlen_bits(input logic [1:0] code);
        case (wlen_e'(code))
            WL_16:   return 6'd16;
            WL_20:   return 6'd20;
            WL_24:   return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/i2s_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser for a group of slow asynchronous inputs.
// Assumes each input holds its level for several system clock cycles,
// so that all bits of the group can be treated as coherent.
module i2s_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages per input bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/i2s_rx.sv
`timescale 1ns/1ps
// Record-side deserialiser. On each bit clock rising tick it samples the
// data bit. It tracks the frame clock over the last two ticks, so that the
// bit taken at tick k belongs to the channel seen at tick k-1. That bit is
// a word's MSB when the frame clock differed between ticks k-1 and k-2.
// Assumes the tick is a one-cycle pulse and lr/din come from the same
// synchroniser as the tick.
module i2s_rx
    import i2s_port_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int MAX_W    = 32,
    parameter int CNT_W    = $clog2(MAX_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                lr,
    input  logic                din,
    input  logic [1:0]          wlen,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    localparam logic [CNT_W-1:0] MAX_N = CNT_W'(MAX_W);

    logic                lr1, lr2;
    logic [1:0]          seen;
    logic [CNT_W-1:0]    cnt, nlen;
    logic [MAX_W-1:0]    shreg;
    logic                chan;
    logic                left_got;
    logic [SAMPLE_W-1:0] left_q;

    logic [MAX_W-1:0]    shifted, aligned;
    logic [SAMPLE_W-1:0] sample;
    logic                start, busy, last;

    // Word boundary detection and left alignment of the word being completed.
    always_comb begin
        start   = (seen == 2'd2) && (lr1 != lr2);
        busy    = (cnt != '0) && (cnt < nlen);
        last    = busy && ((cnt + 1'b1) == nlen);
        shifted = {shreg[MAX_W-2:0], din};
        aligned = shifted << (MAX_N - nlen);
        sample  = aligned[MAX_W-1 -: SAMPLE_W];
    end

    // Bit capture, channel storage and pair strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr1      <= 1'b0;
            lr2      <= 1'b0;
            seen     <= '0;
            cnt      <= '0;
            nlen     <= '0;
            shreg    <= '0;
            chan     <= 1'b0;
            left_got <= 1'b0;
            left_q   <= '0;
            left_o   <= '0;
            right_o  <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (tick) begin
                lr1 <= lr;
                lr2 <= lr1;
                if (seen != 2'd2) seen <= seen + 2'd1;
                if (start) begin
                    shreg <= MAX_W'(din);
                    cnt   <= CNT_W'(1);
                    nlen  <= CNT_W'(wlen_bits(wlen));
                    chan  <= lr1;
                end else if (busy) begin
                    shreg <= shifted;
                    cnt   <= cnt + 1'b1;
                    if (last) begin
                        if (!chan) begin
                            left_q   <= sample;
                            left_got <= 1'b1;
                        end else if (left_got) begin
                            left_o   <= left_q;
                            right_o  <= sample;
                            valid_o  <= 1'b1;
                            left_got <= 1'b0;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2s_tx.sv
`timescale 1ns/1ps
// Playback-side serialiser. The frame clock is sampled on rising ticks,
// where it is stable. The value driven at a falling tick belongs to the
// channel sampled at the rise just before it. A new word starts when the
// last two rise samples differ. The sample pair is captured when a rise
// shows the frame clock has gone low, and the request strobe is raised at
// the same time. Assumes rise and fall ticks never coincide.
module i2s_tx
    import i2s_port_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int MAX_W    = 32,
    parameter int CNT_W    = $clog2(MAX_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise_tick,
    input  logic                fall_tick,
    input  logic                lr,
    input  logic [1:0]          wlen,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                dout,
    output logic                req
);
    logic                lr1, lr2;
    logic [1:0]          seen;
    logic [CNT_W-1:0]    cnt, nlen;
    logic [MAX_W-1:0]    shreg, frame;
    logic [SAMPLE_W-1:0] hold_l, hold_r;
    logic                start, busy;

    // Word start decision and MSB-aligned word for the starting channel.
    always_comb begin
        start = (seen == 2'd2) && (lr1 != lr2);
        busy  = (cnt != '0) && (cnt < nlen);
        frame = MAX_W'(lr1 ? hold_r : hold_l) << (MAX_W - SAMPLE_W);
    end

    // Frame clock history, pair capture, request strobe and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr1    <= 1'b0;
            lr2    <= 1'b0;
            seen   <= '0;
            cnt    <= '0;
            nlen   <= '0;
            shreg  <= '0;
            hold_l <= '0;
            hold_r <= '0;
            dout   <= 1'b0;
            req    <= 1'b0;
        end else begin
            req <= 1'b0;
            if (rise_tick) begin
                lr1 <= lr;
                lr2 <= lr1;
                if (seen != 2'd2) seen <= seen + 2'd1;
                if ((seen != 2'd0) && lr1 && !lr) begin
                    req    <= 1'b1;
                    hold_l <= tx_left;
                    hold_r <= tx_right;
                end
            end
            if (fall_tick) begin
                if (start) begin
                    dout  <= frame[MAX_W-1];
                    shreg <= frame << 1;
                    cnt   <= CNT_W'(1);
                    nlen  <= CNT_W'(wlen_bits(wlen));
                end else if (busy) begin
                    dout  <= shreg[MAX_W-1];
                    shreg <= shreg << 1;
                    cnt   <= cnt + 1'b1;
                end else begin
                    dout  <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/i2s_slave_port.sv
`timescale 1ns/1ps
// I2S slave port top. The codec drives the bit clock and both frame
// clocks. This level synchronises them with the record data, finds the
// bit clock edges, and hands the ticks to the record and playback engines.
// Assumes the system clock is at least eight times the bit clock.
module i2s_slave_port #(
    parameter int SAMPLE_W = 24,
    parameter int MAX_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk,
    input  logic                adclrck,
    input  logic                adcdat,
    input  logic                daclrck,
    output logic                dacdat,
    input  logic [1:0]          wlen,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                tx_req
);
    localparam int CNT_W = $clog2(MAX_W + 1);

    logic [3:0] sync_q;
    logic       bclk_s, adc_lr_s, adc_dat_s, dac_lr_s;
    logic       bclk_d, bclk_rise, bclk_fall;

    i2s_sync #(.W(4)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({daclrck, adcdat, adclrck, bclk}),
        .q     (sync_q)
    );

    assign {dac_lr_s, adc_dat_s, adc_lr_s, bclk_s} = sync_q;

    // Previous synchronised bit clock level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= bclk_s;
    end

    assign bclk_rise = bclk_s & ~bclk_d;
    assign bclk_fall = ~bclk_s & bclk_d;

    i2s_rx #(.SAMPLE_W(SAMPLE_W), .MAX_W(MAX_W), .CNT_W(CNT_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (bclk_rise),
        .lr      (adc_lr_s),
        .din     (adc_dat_s),
        .wlen    (wlen),
        .left_o  (rx_left),
        .right_o (rx_right),
        .valid_o (rx_valid)
    );

    i2s_tx #(.SAMPLE_W(SAMPLE_W), .MAX_W(MAX_W), .CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_tick (bclk_rise),
        .fall_tick (bclk_fall),
        .lr        (dac_lr_s),
        .wlen      (wlen),
        .tx_left   (tx_left),
        .tx_right  (tx_right),
        .dout      (dacdat),
        .req       (tx_req)
    );
endmodule

// File: rtl/i2s_slave_port_chk.sv
`timescale 1ns/1ps
// Protocol checker for the I2S slave port. It is bound to the top and
// watches the strobes, the playback line and the internal bit clock ticks.
module i2s_slave_port_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic tx_req,
    input logic dacdat,
    input logic rise_tick,
    input logic fall_tick,
    input logic dac_lr
);
    a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r4_valid_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rise_tick));

    a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

    a_r7_req_in_left: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> ($past(rise_tick) && !$past(dac_lr)));

    a_r5_dac_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dacdat) |-> $past(fall_tick));

    a_r9_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rx_valid && !tx_req && !dacdat));
endmodule

bind i2s_slave_port i2s_slave_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .tx_req    (tx_req),
    .dacdat    (dacdat),
    .rise_tick (bclk_rise),
    .fall_tick (bclk_fall),
    .dac_lr    (dac_lr_s)
);

// File: tb/sim_i2s_slave_port.sv
`timescale 1ns/1ps
// Bench: acts as the clock-master codec with 32-bit channel slots.
// Sweeps all four word lengths over four sample patterns each, and
// checks both directions against values computed arithmetically.
module sim_i2s_slave_port;
    localparam int NF   = 16;
    localparam int SLOT = 32;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        bclk = 1'b0, adclrck = 1'b1, adcdat = 1'b0, daclrck = 1'b1;
    logic [1:0]  wlen = 2'd0;
    logic        dacdat, rx_valid, tx_req;
    logic [23:0] rx_left, rx_right, tx_left, tx_right;

    int total = 0, bad = 0, rx_seen = 0, req_seen = 0;
    bit done = 1'b0;

    logic [23:0] erx_l [NF];
    logic [23:0] erx_r [NF];
    logic [31:0] cap [2];
    logic        prev_bit = 1'b0;
    int          pf = -1, pc = 0, pk = 0;

    function automatic int nbits(input int code);
        case (code)
            0: return 16;
            1: return 20;
            2: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] rxword(input int f, input int c, input int n);
        logic [31:0] v, m;
        case (f % 4)
            0: v = 32'hFFFF_FFFF;
            1: v = (32'h1 << (n - 1)) | 32'(c);
            2: v = c ? 32'h3333_3333 : 32'hAAAA_AAAA;
            default: v = (32'(f) * 32'h9E37_79B9) ^ (c ? 32'h7F4A_7C15 : 32'h0123_4567);
        endcase
        m = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
        return v & m;
    endfunction

    function automatic logic [23:0] txpat(input int f, input int c);
        case (f % 4)
            0: return c ? 24'hFFFFFF : 24'h000001;
            1: return 24'h800000 | 24'(c);
            2: return c ? 24'h5A5A5A : 24'hA5A5A5;
            default: return 24'((32'(f) * 32'h00B7_E151) ^ (c ? 32'h3C3C3C : 32'hC0FFEE));
        endcase
    endfunction

    function automatic logic [23:0] exp_rx(input logic [31:0] w, input int n);
        logic [31:0] a;
        a = w << (32 - n);
        return a[31:8];
    endfunction

    function automatic logic [31:0] exp_dac(input logic [23:0] s, input int n);
        logic [31:0] a;
        a = {s, 8'h00};
        return (a >> (32 - n)) << (32 - n);
    endfunction

    assign tx_left  = txpat(req_seen, 0);
    assign tx_right = txpat(req_seen, 1);

    i2s_slave_port u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .adclrck  (adclrck),
        .adcdat   (adcdat),
        .daclrck  (daclrck),
        .dacdat   (dacdat),
        .wlen     (wlen),
        .rx_left  (rx_left),
        .rx_right (rx_right),
        .rx_valid (rx_valid),
        .tx_left  (tx_left),
        .tx_right (tx_right),
        .tx_req   (tx_req)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Received pair monitor (R1, R2, R3, R4).
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (rx_seen < NF) begin
                chk(rx_left == erx_l[rx_seen], "R1 R2 R3 left sample", 32'(rx_left),
                    32'(erx_l[rx_seen]));
                chk(rx_right == erx_r[rx_seen], "R1 R2 R3 right sample", 32'(rx_right),
                    32'(erx_r[rx_seen]));
            end
            rx_seen = rx_seen + 1;
        end
    end

    // Request monitor: presents the next pair after each request (R7).
    always @(negedge clk) begin
        if (rst_n && tx_req) req_seen = req_seen + 1;
    end

    // One bit period as codec master: frame clock and data change with the fall.
    task automatic period(input logic lr, input logic d, output logic got);
        @(negedge clk);
        bclk = 1'b0; adclrck = lr; daclrck = lr; adcdat = d;
        repeat (HALF) @(negedge clk);
        bclk = 1'b1;
        got = dacdat;
        repeat (HALF) @(negedge clk);
    endtask

    // One period: the data bit lags the frame clock by one period (I2S).
    task automatic step(input logic lr, input int f, input int c, input int k,
                        input logic sb);
        logic got;
        period(lr, prev_bit, got);
        if (pf >= 0) begin
            cap[pc][31 - pk] = got;
            if (pk == SLOT - 1)
                chk(cap[pc] == exp_dac(txpat(pf, pc), nbits(pf / 4)),
                    (pc == 0) ? "R5 R6 R8 left playback word" : "R5 R6 R8 right playback word",
                    cap[pc], exp_dac(txpat(pf, pc), nbits(pf / 4)));
        end
        prev_bit = sb;
        pf = f; pc = c; pk = k;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(rx_valid == 1'b0 && tx_req == 1'b0 && dacdat == 1'b0, "R9 strobes in reset",
            {29'd0, rx_valid, tx_req, dacdat}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_left == 24'd0 && rx_right == 24'd0, "R9 sample outputs after reset",
            32'(rx_left | rx_right), 32'd0);
        chk(dacdat == 1'b0 && rx_valid == 1'b0, "R9 line after reset",
            {30'd0, dacdat, rx_valid}, 32'd0);

        // Preamble: a right slot with silent data.
        for (int i = 0; i < 4; i++) step(1'b1, -1, 1, SLOT - 4 + i, 1'b0);

        for (int f = 0; f < NF; f++) begin
            int n;
            logic [31:0] w;
            wlen = 2'(f / 4);
            n = nbits(f / 4);
            erx_l[f] = exp_rx(rxword(f, 0, n), n);
            erx_r[f] = exp_rx(rxword(f, 1, n), n);
            for (int c = 0; c < 2; c++) begin
                w = rxword(f, c, n);
                // R3: padding bits after the word are ones in odd frames.
                for (int k = 0; k < SLOT; k++)
                    step(logic'(c), f, c, k, (k < n) ? w[n - 1 - k] : logic'(f % 2));
            end
        end
        step(1'b0, -1, 0, 0, 1'b0);
        step(1'b0, -1, 0, 1, 1'b0);
        repeat (40) @(negedge clk);

        chk(rx_seen == NF, "R4 pair strobe count", 32'(rx_seen), 32'(NF));
        chk(req_seen == NF + 1, "R7 request count", 32'(req_seen), 32'(NF + 1));
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", rx_seen, NF);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule